// File: doc/BRIEF.md
# Five-Stage Pipeline Flow Controller

This block sequences an in-order pipeline of five stages: fetch (stage 0), decode (1), operand fetch (2), execute (3) and writeback (4). It keeps a valid bit and an instruction tag for every stage past fetch. It also owns the fetch address, and the tag of a fetched instruction is its fetch address. The instruction source reports whether the word at the fetch address is a branch, its target and its annul bit. The branch unit reports whether the branch now in execute is taken. The operand-fetch stage can ask to hold.

From these inputs the block drives a load enable and a kill strobe for each stage. It also drives a redirect strobe with a target, and it retires one tag per cycle at writeback. A build-time parameter picks how a taken branch is handled. In flush mode the three younger stages are discarded. In delay-slot mode the instruction right behind the branch always runs, and a branch that is not taken may cancel that instruction through its annul bit. The program must not place a branch in a delay slot.

Top module: `pfc_top`

## Requirements
- R1: While `rst_n` is low, `fetchPc` is 0 and `exValid`, `wbValid` and `redirect` are 0.
- R2: With no stall and no taken branch, `fetchPc` rises by one every cycle, and consecutive tags retire on consecutive cycles.
- R3: Suppose `ofStall` is high while operand fetch holds a valid instruction. Then `advance` bits 0 to 2 are 0 and `advance` bits 3 and 4 are 1, where bit k belongs to stage k. Fetch, decode and operand fetch hold their contents, and execute receives a bubble.
- R4: A stall of N cycles on an instruction in operand fetch delays its retirement by exactly N cycles. Program order is kept.
- R5: `redirect` is high only in a cycle where execute holds a valid branch and `exTaken` is high. `redirectTarget` then equals that branch's target, and `fetchPc` equals it on the next cycle. A branch that is not taken changes nothing in the sequential flow.
- R6: With DELAY_SLOT=0, a taken branch drives `kill` = 5'b00111 (bits 0 to 2: fetch, decode, operand fetch). The target retires 4 cycles after the branch, which is 3 lost cycles. The annul bit has no effect in this mode.
- R7: With DELAY_SLOT=1, a taken branch drives `kill` = 5'b00011. The delay slot retires on the cycle after the branch, and the target retires 3 cycles after the slot, which is 2 lost cycles. The slot always runs on a taken branch, even when the annul bit is set.
- R8: With DELAY_SLOT=1, a branch that is not taken and has its annul bit set drives `kill` = 5'b00100. Its slot never retires, and the next sequential instruction retires 2 cycles after the branch. With the annul bit clear, `kill` stays 0 and the slot retires normally.
- R9: Killed instructions never reach writeback. The retired tag sequence equals the program path: the sequential path, the branch targets and the surviving delay slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofStall | input | 1 | Hold request from the operand-fetch stage |
| fetchIsBranch | input | 1 | Word at `fetchPc` is a branch |
| fetchAnnul | input | 1 | Annul bit of the word at `fetchPc` |
| fetchTarget | input | TAG_W | Branch target of the word at `fetchPc` |
| exTaken | input | 1 | Outcome of the branch now in execute |
| fetchPc | output | TAG_W | Current fetch address, which is also the tag of the fetched word |
| exValid | output | 1 | Execute stage holds an instruction |
| exTag | output | TAG_W | Tag in execute |
| exIsBranch | output | 1 | Instruction in execute is a branch |
| redirect | output | 1 | Fetch restarts at `redirectTarget` on the next cycle |
| redirectTarget | output | TAG_W | Restart address |
| advance | output | 5 | Per-stage load enable; bit k is stage k |
| kill | output | 5 | Per-stage discard strobe; bit k is stage k |
| wbValid | output | 1 | An instruction retires this cycle |
| wbTag | output | TAG_W | Retiring tag |

## Verification
Both modes run side by side on the same program. Straight-line code with one injected multi-cycle stall separates a correct single bubble from a lost or duplicated instruction and from a wrong hold length. A branch mix is then run: taken, not taken, annulled and not annulled, back-to-back taken, and a taken branch with its annul bit set. This mix separates flush from delay-slot behaviour through the exact retired sequence and the cycle gap before each retirement. The kill and redirect strobes are compared every cycle in which execute holds a branch.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NUM_STAGES = 5;

  typedef enum logic [2:0] {
    STG_IF = 3'd0,
    STG_ID = 3'd1,
    STG_OF = 3'd2,
    STG_EX = 3'd3,
    STG_WB = 3'd4
  } stage_e;

  // strobes from control to the stage registers
  typedef struct packed {
    logic stall;
    logic redirect;
    logic killIf;
    logic killId;
    logic killOf;
  } flowCtl_t;
endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic     ofValid,
  input  logic     ofStallReq,
  input  logic     exValid,
  input  logic     exBranch,
  input  logic     exAnnul,
  input  logic     exTaken,
  output flowCtl_t ctl
);
  logic takenNow;
  logic killOfNow;

  assign takenNow = exValid & exBranch & exTaken;

  generate
    if (DELAY_SLOT) begin : g_slot
      // slot survives a taken branch; annulled only when falling through
      assign killOfNow = exValid & exBranch & ~exTaken & exAnnul;
    end else begin : g_flush
      assign killOfNow = takenNow;
    end
  endgenerate

  always_comb begin
    ctl.redirect = takenNow;
    ctl.killIf   = takenNow;
    ctl.killId   = takenNow;
    ctl.killOf   = killOfNow;
    ctl.stall    = ofStallReq & ofValid & ~killOfNow;
  end
endmodule

// File: rtl/pfc_stages.sv
module pfc_stages
  import pfc_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  flowCtl_t             ctl,
  input  logic                 fetchIsBranch,
  input  logic                 fetchAnnul,
  input  logic [TAG_W-1:0]     fetchTarget,
  output logic [TAG_W-1:0]     fetchPc,
  output logic                 ofValid,
  output logic                 exValid,
  output logic [TAG_W-1:0]     exTag,
  output logic                 exIsBranch,
  output logic                 exAnnul,
  output logic [TAG_W-1:0]     exTarget,
  output logic [NUM_STAGES-1:0] advance,
  output logic [NUM_STAGES-1:0] kill,
  output logic                 wbValid,
  output logic [TAG_W-1:0]     wbTag
);
  localparam int FIRST = int'(STG_ID);
  localparam int LAST  = int'(STG_EX);

  logic [TAG_W-1:0] pc;
  logic             vld [FIRST:LAST];
  logic [TAG_W-1:0] tag [FIRST:LAST];
  logic             br  [FIRST:LAST];
  logic             ann [FIRST:LAST];
  logic [TAG_W-1:0] tgt [FIRST:LAST];

  logic             inV   [FIRST:LAST];
  logic [TAG_W-1:0] inT   [FIRST:LAST];
  logic             inBr  [FIRST:LAST];
  logic             inAnn [FIRST:LAST];
  logic [TAG_W-1:0] inTgt [FIRST:LAST];
  logic             load  [FIRST:LAST];
  logic             held  [FIRST:LAST];
  logic             wbV;
  logic [TAG_W-1:0] wbT;

  always_comb begin
    // decode takes the fetched word
    inV[1] = ~ctl.killIf;        inT[1] = pc;
    inBr[1] = fetchIsBranch;     inAnn[1] = fetchAnnul;  inTgt[1] = fetchTarget;
    // operand fetch takes decode
    inV[2] = vld[1] & ~ctl.killId; inT[2] = tag[1];
    inBr[2] = br[1];             inAnn[2] = ann[1];      inTgt[2] = tgt[1];
    // execute takes operand fetch, or a bubble while it holds
    inV[3] = vld[2] & ~ctl.killOf & ~ctl.stall; inT[3] = tag[2];
    inBr[3] = br[2];             inAnn[3] = ann[2];      inTgt[3] = tgt[2];
    load[1] = ~ctl.stall;  held[1] = ctl.killId;
    load[2] = ~ctl.stall;  held[2] = ctl.killOf;
    load[3] = 1'b1;        held[3] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      wbV <= 1'b0;
      wbT <= '0;
      for (int k = FIRST; k <= LAST; k++) vld[k] <= 1'b0;
    end else begin
      if (ctl.redirect)    pc <= tgt[LAST];
      else if (!ctl.stall) pc <= pc + TAG_W'(1);
      for (int k = FIRST; k <= LAST; k++) begin
        if (load[k]) begin
          vld[k] <= inV[k];
          tag[k] <= inT[k];
          br[k]  <= inBr[k];
          ann[k] <= inAnn[k];
          tgt[k] <= inTgt[k];
        end else if (held[k]) begin
          vld[k] <= 1'b0;
        end
      end
      wbV <= vld[LAST];
      wbT <= tag[LAST];
    end
  end

  assign fetchPc    = pc;
  assign ofValid    = vld[2];
  assign exValid    = vld[LAST];
  assign exTag      = tag[LAST];
  assign exIsBranch = br[LAST];
  assign exAnnul    = ann[LAST];
  assign exTarget   = tgt[LAST];
  assign wbValid    = wbV;
  assign wbTag      = wbT;
  assign advance    = {1'b1, 1'b1, ~ctl.stall, ~ctl.stall, ~ctl.stall | ctl.redirect};
  assign kill       = {2'b00, ctl.killOf, ctl.killId, ctl.killIf};
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ofStall,
  input  logic             fetchIsBranch,
  input  logic             fetchAnnul,
  input  logic [TAG_W-1:0] fetchTarget,
  input  logic             exTaken,
  output logic [TAG_W-1:0] fetchPc,
  output logic             exValid,
  output logic [TAG_W-1:0] exTag,
  output logic             exIsBranch,
  output logic             redirect,
  output logic [TAG_W-1:0] redirectTarget,
  output logic [4:0]       advance,
  output logic [4:0]       kill,
  output logic             wbValid,
  output logic [TAG_W-1:0] wbTag
);
  flowCtl_t         ctl;
  logic             ofValid;
  logic             exAnnul;
  logic [TAG_W-1:0] exTarget;

  pfc_ctrl #(.DELAY_SLOT(DELAY_SLOT)) u_ctrl (
    .ofValid   (ofValid),
    .ofStallReq(ofStall),
    .exValid   (exValid),
    .exBranch  (exIsBranch),
    .exAnnul   (exAnnul),
    .exTaken   (exTaken),
    .ctl       (ctl)
  );

  pfc_stages #(.TAG_W(TAG_W)) u_stages (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .fetchIsBranch(fetchIsBranch),
    .fetchAnnul   (fetchAnnul),
    .fetchTarget  (fetchTarget),
    .fetchPc      (fetchPc),
    .ofValid      (ofValid),
    .exValid      (exValid),
    .exTag        (exTag),
    .exIsBranch   (exIsBranch),
    .exAnnul      (exAnnul),
    .exTarget     (exTarget),
    .advance      (advance),
    .kill         (kill),
    .wbValid      (wbValid),
    .wbTag        (wbTag)
  );

  assign redirect       = ctl.redirect;
  assign redirectTarget = exTarget;
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk
  import pfc_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input flowCtl_t         ctl,
  input logic [TAG_W-1:0] fetchPc,
  input logic             exValid,
  input logic             exIsBranch,
  input logic             exTaken,
  input logic             redirect,
  input logic [TAG_W-1:0] redirectTarget
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stall && !redirect |=> $stable(fetchPc));

  // R3
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stall |=> !exValid);

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.stall && !redirect |=> fetchPc == $past(fetchPc) + TAG_W'(1));

  // R5
  redir_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetchPc == $past(redirectTarget));

  // R5
  redir_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> exValid && exIsBranch && exTaken);

  generate
    if (DELAY_SLOT) begin : g_slot
      // R7
      slot_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect && !ctl.stall |=> exValid);
    end else begin : g_flush
      // R6
      flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !exValid);
    end
  endgenerate
endmodule

bind pfc_top pfc_chk #(.TAG_W(TAG_W), .DELAY_SLOT(DELAY_SLOT)) u_pfc_chk (.*);

// File: tb/test_pfc_top.sv
module test_pfc_top;
  localparam int M = 30;

  typedef struct { logic [7:0] tag; int gap; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ofStall = 1'b0;
  logic running = 1'b0;
  int total = 0, bad = 0, cyc = 0;
  int lastCyc [2];
  exp_t q0[$], q1[$];

  logic       pBr  [256];
  logic       pAnn [256];
  logic       pTk  [256];
  logic [7:0] pTgt [256];

  logic [7:0] fpcA, exTagA, rtgtA, wbTagA, fpcB, exTagB, rtgtB, wbTagB;
  logic       exVA, exBrA, redA, wbVA, exVB, exBrB, redB, wbVB;
  logic [4:0] advA, killA, advB, killB;

  always #5 clk = ~clk;

  pfc_top #(.TAG_W(8), .DELAY_SLOT(1'b0)) i_pfc_top (
    .clk(clk), .rst_n(rst_n), .ofStall(ofStall),
    .fetchIsBranch(pBr[fpcA]), .fetchAnnul(pAnn[fpcA]), .fetchTarget(pTgt[fpcA]),
    .exTaken(pTk[exTagA]), .fetchPc(fpcA), .exValid(exVA), .exTag(exTagA),
    .exIsBranch(exBrA), .redirect(redA), .redirectTarget(rtgtA),
    .advance(advA), .kill(killA), .wbValid(wbVA), .wbTag(wbTagA));

  pfc_top #(.TAG_W(8), .DELAY_SLOT(1'b1)) i_pfc_top_ds (
    .clk(clk), .rst_n(rst_n), .ofStall(ofStall),
    .fetchIsBranch(pBr[fpcB]), .fetchAnnul(pAnn[fpcB]), .fetchTarget(pTgt[fpcB]),
    .exTaken(pTk[exTagB]), .fetchPc(fpcB), .exValid(exVB), .exTag(exTagB),
    .exIsBranch(exBrB), .redirect(redB), .redirectTarget(rtgtB),
    .advance(advB), .kill(killB), .wbValid(wbVB), .wbTag(wbTagB));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int ds, input int tag, input int gap);
    exp_t e;
    e.tag = 8'(tag);
    e.gap = gap;
    if (ds != 0) q1.push_back(e); else q0.push_back(e);
  endtask

  // reference path of retirements with expected gap before each one
  task automatic buildExp(input int ds, input int stallTag, input int stallN);
    int pc = 0, extra = 0, n = 0, g;
    while (n < M) begin
      g = 1 + extra + ((pc == stallTag) ? stallN : 0);
      extra = 0;
      push(ds, pc, (n == 0) ? -1 : g);
      n++;
      if (pBr[pc]) begin
        if (ds == 0) begin
          if (pTk[pc]) begin extra = 3; pc = int'(pTgt[pc]); end
          else pc = pc + 1;
        end else if (pTk[pc] || !pAnn[pc]) begin
          if (n < M) begin push(ds, pc + 1, 1); n++; end
          if (pTk[pc]) begin extra = 2; pc = int'(pTgt[pc]); end
          else pc = pc + 2;
        end else begin
          extra = 1;
          pc = pc + 2;
        end
      end else pc = pc + 1;
    end
  endtask

  task automatic monOne(input int ds, input logic wbV, input logic [7:0] wbT,
                        input logic exV, input logic [7:0] exT, input logic red,
                        input logic [7:0] rtgt, input logic [4:0] kl, input logic [4:0] adv);
    exp_t e;
    int expKill;
    bit tk;
    if (wbV && ((ds != 0) ? q1.size() : q0.size()) > 0) begin
      e = (ds != 0) ? q1.pop_front() : q0.pop_front();
      // R9 sequence; R2/R4/R6/R7/R8 gaps
      check(wbT == e.tag, $sformatf("R9 tag ds=%0d", ds), int'(wbT), int'(e.tag));
      if (e.gap >= 0)
        check(cyc - lastCyc[ds] == e.gap, $sformatf("R2/R4/R6/R7/R8 gap ds=%0d tag=%0d", ds, e.tag),
              cyc - lastCyc[ds], e.gap);
      lastCyc[ds] = cyc;
    end
    if (exV && pBr[exT]) begin
      tk = pTk[exT];
      expKill = tk ? ((ds != 0) ? 5'b00011 : 5'b00111)
                   : (((ds != 0) && pAnn[exT]) ? 5'b00100 : 5'b00000);
      // R5 redirect, R6/R7/R8 kill pattern
      check(red == tk, $sformatf("R5 redirect ds=%0d", ds), int'(red), int'(tk));
      check(kl == 5'(expKill), $sformatf("R6/R7/R8 kill ds=%0d", ds), int'(kl), expKill);
      if (tk) check(rtgt == pTgt[exT], "R5 target", int'(rtgt), int'(pTgt[exT]));
    end else begin
      check(red == 1'b0, "R5 no redirect", int'(red), 0);
    end
    if (ofStall) check(adv == 5'b11000, "R3 advance", int'(adv), 24);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (running) begin
      monOne(0, wbVA, wbTagA, exVA, exTagA, redA, rtgtA, killA, advA);
      monOne(1, wbVB, wbTagB, exVB, exTagB, redB, rtgtB, killB, advB);
    end
  end

  task automatic clearProg();
    for (int i = 0; i < 256; i++) begin
      pBr[i] = 1'b0; pAnn[i] = 1'b0; pTk[i] = 1'b0; pTgt[i] = 8'd0;
    end
  endtask

  task automatic setBr(input int at, input bit tk, input bit an, input int tg);
    pBr[at] = 1'b1; pTk[at] = tk; pAnn[at] = an; pTgt[at] = 8'(tg);
  endtask

  task automatic runPhase(input int stallTag, input int stallN);
    rst_n = 1'b0;
    running = 1'b0;
    q0.delete(); q1.delete();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fpcA == 8'd0 && fpcB == 8'd0, "R1 fetchPc", int'(fpcA) + int'(fpcB), 0);
    check(!exVA && !exVB && !wbVA && !wbVB, "R1 valids", int'(exVA | exVB | wbVA | wbVB), 0);
    check(!redA && !redB, "R1 redirect", int'(redA | redB), 0);
    buildExp(0, stallTag, stallN);
    buildExp(1, stallTag, stallN);
    #1 rst_n = 1'b1;
    running = 1'b1;
    if (stallN > 0) begin
      @(negedge clk);
      while (!(exVA && exTagA == 8'(stallTag - 1))) @(negedge clk);
      #1 ofStall = 1'b1;
      repeat (stallN) @(negedge clk);
      #1 ofStall = 1'b0;
    end
    repeat (70) @(negedge clk);
    running = 1'b0;
    // R9 every expected retirement seen
    check(q0.size() == 0, "R9 flush drained", q0.size(), 0);
    check(q1.size() == 0, "R9 slot drained", q1.size(), 0);
  endtask

  initial begin
    clearProg();
    // straight-line code, tag 7 held 3 cycles in operand fetch (R2, R3, R4)
    runPhase(7, 3);
    // branch mix (R5..R9)
    clearProg();
    setBr(4, 1'b1, 1'b0, 20);
    setBr(22, 1'b0, 1'b0, 90);
    setBr(26, 1'b0, 1'b1, 90);
    setBr(30, 1'b1, 1'b1, 40);
    setBr(44, 1'b1, 1'b0, 60);
    setBr(60, 1'b1, 1'b0, 70);
    setBr(72, 1'b0, 1'b1, 90);
    runPhase(-10, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule